// File: doc/BRIEF.md
# Descriptor-Driven DMA Stream Writer

This block moves an incoming data stream into host memory under the direction of a queue of transfer descriptors. Software loads descriptors into a small descriptor FIFO. Each descriptor is a 32-bit byte address and a 24-bit byte length. The writer takes the descriptor at the head of the queue and turns the matching number of input beats into write requests. These requests leave on a valid/ready memory port that carries an address, a data word and a last flag.

In programmed mode each descriptor is retired from the queue once it is used, so software has to keep the queue filled. In loop mode a retired descriptor is put back at the tail of the queue, and transfers cycle with no further software action. An enable input starts and stops the engine. A build-time parameter decides what happens to input while the engine is off: it is either accepted and dropped, or held off. A wrapping counter of completed descriptors lets software track progress.

Top module: `dma_stream_writer`

## Requirements
- R1: After reset, req_valid is low, done_count is 0, desc_full and desc_overflow are low, and in_ready equals the disabled-input policy (high when DISCARD_WHEN_OFF=1, low when 0).
- R2: In programmed mode each descriptor is used exactly once, in the order written, and is then removed from the queue.
- R3: While enable is high and no descriptor is queued or in use, in_ready is low.
- R4: With DISCARD_WHEN_OFF=1 and enable low (and no request in progress), in_ready is high and accepted beats produce no req_valid.
- R5: With DISCARD_WHEN_OFF=0 and enable low, in_ready is low.
- R6: Descriptors written while enable is low are kept and are not consumed until enable goes high.
- R7: A descriptor of length L bytes moves ceil(L / (DATA_W/8)) beats; with the default 32-bit bus, a length of 6 moves 2 beats and a length of 10 moves 3.
- R8: A descriptor is cut into requests of at most MAX_PAYLOAD bytes (4 beats by default). req_addr is the descriptor address plus the bytes already sent, and it is held for the whole request. req_last is high on the final beat of each request.
- R9: During a transfer, req_valid follows in_valid, req_data equals in_data, and in_ready follows req_ready, so memory back-pressure stalls the input.
- R10: done_count increments by one for each fully moved descriptor and wraps modulo 2^CNT_W (16 by default).
- R11: In loop mode each completed descriptor is written back at the tail of the queue, so the queued descriptors repeat in order indefinitely.
- R12: If enable drops in the middle of a descriptor, the request already begun is completed. The descriptor is then dropped without being counted, and the next transfer starts with the following descriptor.
- R13: desc_full is high when FIFO_DEPTH descriptors are queued. A descriptor write while full is ignored and sets desc_overflow, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine run control |
| loop_mode | input | 1 | 1: recycle completed descriptors; 0: programmed mode |
| desc_wr_valid | input | 1 | Software descriptor write strobe |
| desc_wr_addr | input | 32 | Descriptor byte address |
| desc_wr_len | input | 24 | Descriptor byte length |
| desc_full | output | 1 | Descriptor queue full |
| desc_overflow | output | 1 | Sticky: a write arrived while full |
| in_valid | input | 1 | Input stream beat valid |
| in_ready | output | 1 | Input stream beat accepted |
| in_data | input | DATA_W | Input stream data |
| req_valid | output | 1 | Memory write request beat valid |
| req_ready | input | 1 | Memory port accepts beat |
| req_addr | output | 32 | Start byte address of current request |
| req_data | output | DATA_W | Write data |
| req_last | output | 1 | Final beat of current request |
| done_count | output | CNT_W | Completed descriptor count, wrapping |

## Verification
The bench targets request splitting at the payload boundary and the rounding of lengths that are not whole beats. A design that got these wrong would move the wrong address into the second request or put req_last on the wrong beat. It drops enable partway through a request and checks that the remaining beats still go out at the original address. After that it checks that the next beat is discarded and that the following descriptor starts cleanly; a faulty design would truncate the request, count the dropped descriptor or resume it. It overfills the queue and runs loop mode past the counter wrap. A design that admitted the extra write, lost recycled entries or saturated the counter would show a wrong address sequence or a wrong final count. A held-off copy built with the other disabled policy is checked alongside the main instance; a mix-up of the two policies shows up as in_ready taking the wrong level while enable is low.

// File: rtl/dmaw_pkg.sv
// Shared types for the descriptor-driven stream writer.
package dmaw_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } dmaw_desc_t;
endpackage

// File: rtl/dmaw_desc_fifo.sv
// Descriptor queue: a circular buffer with a combinational head.
// Assumes the caller pushes only when not full (or pops in the same
// cycle), and pops only when not empty.
module dmaw_desc_fifo
    import dmaw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  dmaw_desc_t push_desc,
    input  logic       pop,
    output dmaw_desc_t head,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    dmaw_desc_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_desc;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/dmaw_engine.sv
// Transfer engine: fetches the head descriptor, forwards input beats as
// memory write requests cut at the payload limit, and retires the
// descriptor (pop, plus write-back in loop mode). Retirement waits a
// cycle when software is writing the queue, so the queue has one writer.
// Assumes MAX_PAYLOAD is a multiple of DATA_W/8.
module dmaw_engine
    import dmaw_pkg::*;
#(
    parameter int DATA_W           = 32,
    parameter int MAX_PAYLOAD      = 16,
    parameter int CNT_W            = 4,
    parameter bit DISCARD_WHEN_OFF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              loop_mode,
    input  dmaw_desc_t        head,
    input  logic              fifo_empty,
    input  logic              sw_push,
    output logic              pop,
    output logic              recycle,
    output logic              idle,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              req_last,
    output logic [CNT_W-1:0]  done_count
);
    localparam int BYTES     = DATA_W / 8;
    localparam int BEAT_SH   = $clog2(BYTES);
    localparam int REQ_BEATS = MAX_PAYLOAD / BYTES;
    localparam int BURST_W   = (REQ_BEATS > 1) ? $clog2(REQ_BEATS) : 1;

    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} eng_state_t;

    eng_state_t         state;
    logic [LEN_W-1:0]   remain;
    logic [ADDR_W-1:0]  req_base;
    logic [BURST_W-1:0] burst;
    logic               aborted;

    logic [LEN_W:0]   len_up;
    logic [LEN_W-1:0] head_beats;
    logic             mid_req, active, beat_ok, final_beat, retire;

    // Beat count of the head descriptor, rounding partial beats up.
    always_comb begin
        len_up     = {1'b0, head.len} + (LEN_W + 1)'(BYTES - 1);
        head_beats = LEN_W'(len_up >> BEAT_SH);
    end

    // Stream-to-request datapath and handshake steering.
    always_comb begin
        mid_req    = (burst != '0);
        active     = (state == ST_XFER) && (enable || mid_req);
        final_beat = (remain == LEN_W'(1));
        req_valid  = active && in_valid;
        req_data   = in_data;
        req_addr   = req_base;
        req_last   = active && ((burst == BURST_W'(REQ_BEATS - 1)) || final_beat);
        beat_ok    = active && in_valid && req_ready;
        if (active)       in_ready = req_ready;
        else if (!enable) in_ready = DISCARD_WHEN_OFF;
        else              in_ready = 1'b0;
        retire     = (state == ST_DONE) && !sw_push;
        pop        = retire;
        recycle    = retire && loop_mode && !aborted;
        idle       = (state == ST_IDLE);
    end

    // Descriptor sequencing, address advance and completion count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            remain     <= '0;
            req_base   <= '0;
            burst      <= '0;
            aborted    <= 1'b0;
            done_count <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (enable && !fifo_empty) begin
                        req_base <= head.addr;
                        remain   <= head_beats;
                        burst    <= '0;
                        aborted  <= 1'b0;
                        state    <= (head_beats == '0) ? ST_DONE : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!enable && !mid_req) begin
                        aborted <= 1'b1;
                        state   <= ST_DONE;
                    end else if (beat_ok) begin
                        remain <= remain - 1'b1;
                        if (req_last) begin
                            burst    <= '0;
                            req_base <= req_base + ADDR_W'(MAX_PAYLOAD);
                        end else begin
                            burst <= burst + 1'b1;
                        end
                        if (final_beat) state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (retire) begin
                        state <= ST_IDLE;
                        if (!aborted) done_count <= done_count + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_stream_writer.sv
// Top: descriptor queue plus transfer engine. Software writes go to the
// queue unless it is full; a rejected write sets a sticky overflow flag.
// In loop mode the engine writes the retired head back into the queue.
module dma_stream_writer
    import dmaw_pkg::*;
#(
    parameter int DATA_W           = 32,
    parameter int FIFO_DEPTH       = 4,
    parameter int MAX_PAYLOAD      = 16,
    parameter int CNT_W            = 4,
    parameter bit DISCARD_WHEN_OFF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              loop_mode,
    input  logic              desc_wr_valid,
    input  logic [31:0]       desc_wr_addr,
    input  logic [23:0]       desc_wr_len,
    output logic              desc_full,
    output logic              desc_overflow,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              req_last,
    output logic [CNT_W-1:0]  done_count
);
    dmaw_desc_t head, push_desc;
    logic       fifo_empty, fifo_full, sw_push, pop, recycle, eng_idle;

    // Queue write arbitration: engine write-back only happens when software is not pushing.
    always_comb begin
        sw_push   = desc_wr_valid && !fifo_full;
        push_desc = recycle ? head : '{addr: desc_wr_addr, len: desc_wr_len};
        desc_full = fifo_full;
    end

    // Sticky record of descriptor writes lost to a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                         desc_overflow <= 1'b0;
        else if (desc_wr_valid && fifo_full) desc_overflow <= 1'b1;
    end

    dmaw_desc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sw_push || recycle),
        .push_desc (push_desc),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    dmaw_engine #(
        .DATA_W           (DATA_W),
        .MAX_PAYLOAD      (MAX_PAYLOAD),
        .CNT_W            (CNT_W),
        .DISCARD_WHEN_OFF (DISCARD_WHEN_OFF)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .loop_mode  (loop_mode),
        .head       (head),
        .fifo_empty (fifo_empty),
        .sw_push    (sw_push),
        .pop        (pop),
        .recycle    (recycle),
        .idle       (eng_idle),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_last   (req_last),
        .done_count (done_count)
    );
endmodule

// File: rtl/dmaw_checker.sv
// Protocol checks for the stream writer, bound into every instance.
module dmaw_checker #(
    parameter int CNT_W            = 4,
    parameter bit DISCARD_WHEN_OFF = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             in_ready,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_last,
    input logic [31:0]      req_addr,
    input logic [CNT_W-1:0] done_count,
    input logic             desc_full,
    input logic             desc_overflow,
    input logic             fifo_empty,
    input logic             eng_idle
);
    // R3: an idle, enabled engine with nothing queued holds off input.
    a_r3_empty_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fifo_empty && eng_idle) |-> !in_ready);

    // R4: an idle, disabled engine issues no memory write.
    a_r4_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && eng_idle) |-> !req_valid);

    // R5: held-off policy keeps input blocked while disabled.
    a_r5_block_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!DISCARD_WHEN_OFF && !enable && eng_idle) |-> !in_ready);

    // R8: request address holds between beats of one request.
    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_last) |=> (req_addr == $past(req_addr)));

    // R10: the completion counter only ever steps by one.
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(done_count) |-> (done_count == $past(done_count) + CNT_W'(1)));

    // R13: overflow is sticky and only rises while the queue is full.
    a_r13_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        desc_overflow |=> desc_overflow);
    a_r13_overflow_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_overflow) |-> $past(desc_full));
endmodule

bind dma_stream_writer dmaw_checker #(
    .CNT_W            (CNT_W),
    .DISCARD_WHEN_OFF (DISCARD_WHEN_OFF)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .in_ready      (in_ready),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_last      (req_last),
    .req_addr      (req_addr),
    .done_count    (done_count),
    .desc_full     (desc_full),
    .desc_overflow (desc_overflow),
    .fifo_empty    (fifo_empty),
    .eng_idle      (eng_idle)
);

// File: tb/dma_stream_writer_tb.sv
`timescale 1ns/1ps
module dma_stream_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, loop_mode = 1'b0;
    logic        desc_wr_valid = 1'b0;
    logic [31:0] desc_wr_addr = '0;
    logic [23:0] desc_wr_len = '0;
    logic        desc_full, desc_overflow;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        req_valid, req_ready = 1'b1, req_last;
    logic [31:0] req_addr, req_data;
    logic [3:0]  done_count;

    logic        b_full, b_ovf, b_in_ready, b_req_valid, b_req_last;
    logic [31:0] b_req_addr, b_req_data;
    logic [3:0]  b_done;

    int total = 0, bad = 0;
    logic [31:0] data_seq = 32'hA000_0000;

    always #4 clk = ~clk;

    dma_stream_writer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .loop_mode(loop_mode),
        .desc_wr_valid(desc_wr_valid), .desc_wr_addr(desc_wr_addr), .desc_wr_len(desc_wr_len),
        .desc_full(desc_full), .desc_overflow(desc_overflow),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_last(req_last), .done_count(done_count)
    );

    // Held-off policy copy, never enabled.
    dma_stream_writer #(.DISCARD_WHEN_OFF(1'b0)) u_blk (
        .clk(clk), .rst_n(rst_n), .enable(1'b0), .loop_mode(1'b0),
        .desc_wr_valid(desc_wr_valid), .desc_wr_addr(desc_wr_addr), .desc_wr_len(desc_wr_len),
        .desc_full(b_full), .desc_overflow(b_ovf),
        .in_valid(in_valid), .in_ready(b_in_ready), .in_data(in_data),
        .req_valid(b_req_valid), .req_ready(1'b1), .req_addr(b_req_addr),
        .req_data(b_req_data), .req_last(b_req_last), .done_count(b_done)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; loop_mode = 1'b0; in_valid = 1'b0;
        desc_wr_valid = 1'b0; req_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [23:0] l);
        @(negedge clk);
        desc_wr_valid = 1'b1; desc_wr_addr = a; desc_wr_len = l;
        @(posedge clk); #1;
        desc_wr_valid = 1'b0;
    endtask

    // Offer one beat; expect it forwarded with the given address/last, or dropped.
    task automatic send_beat(input logic [31:0] ea, input bit el, input bit fwd, input string tag);
        int guard = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = data_seq;
        #1;
        while (!in_ready && guard < 40) begin
            @(negedge clk); #1; guard++;
        end
        check(in_ready, {tag, " in_ready"}, 32'(in_ready), 32'd1);
        if (fwd) begin
            check(req_valid, {tag, " R9 req_valid"}, 32'(req_valid), 32'd1);
            check(req_addr == ea, {tag, " R8 req_addr"}, req_addr, ea);
            check(req_last == el, {tag, " R8 req_last"}, 32'(req_last), 32'(el));
            check(req_data == data_seq, {tag, " R9 req_data"}, req_data, data_seq);
        end else begin
            check(!req_valid, {tag, " dropped beat req_valid"}, 32'(req_valid), 32'd0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        data_seq++;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 in_ready discard policy", 32'(in_ready), 32'd1);
        check(b_in_ready == 1'b0, "R1 in_ready held-off policy", 32'(b_in_ready), 32'd0);
        check(!req_valid && done_count == 0, "R1 req_valid/done_count", {27'd0, done_count, req_valid}, 32'd0);
        check(!desc_full && !desc_overflow, "R1 full/overflow", {30'd0, desc_full, desc_overflow}, 32'd0);

        // R6: load while disabled, nothing consumed
        put_desc(32'h0000_1000, 24'd24);
        put_desc(32'h0000_2000, 24'd10);
        repeat (5) @(negedge clk);
        check(done_count == 0, "R6 nothing consumed while off", 32'(done_count), 32'd0);
        // R4 / R5 policies while disabled
        @(negedge clk); in_valid = 1'b1; #1;
        check(b_in_ready == 1'b0, "R5 held-off in_ready", 32'(b_in_ready), 32'd0);
        in_valid = 1'b0;
        send_beat(32'h0, 1'b0, 1'b0, "R4 discard while off");

        // R2 / R7 / R8 / R9: programmed mode transfer
        @(negedge clk); enable = 1'b1;
        send_beat(32'h1000, 1'b0, 1'b1, "R2 A0");
        @(negedge clk); req_ready = 1'b0; in_valid = 1'b1; #1;
        check(!in_ready, "R9 back-pressure in_ready", 32'(in_ready), 32'd0);
        check(req_valid, "R9 back-pressure req_valid", 32'(req_valid), 32'd1);
        req_ready = 1'b1; in_valid = 1'b0;
        send_beat(32'h1000, 1'b0, 1'b1, "R8 A1");
        send_beat(32'h1000, 1'b0, 1'b1, "R8 A2");
        send_beat(32'h1000, 1'b1, 1'b1, "R8 A3");
        send_beat(32'h1010, 1'b0, 1'b1, "R8 A4");
        send_beat(32'h1010, 1'b1, 1'b1, "R8 A5");
        send_beat(32'h2000, 1'b0, 1'b1, "R7 B0");
        send_beat(32'h2000, 1'b0, 1'b1, "R7 B1");
        send_beat(32'h2000, 1'b1, 1'b1, "R7 B2");
        repeat (4) @(negedge clk);
        check(done_count == 4'd2, "R10 count after two", 32'(done_count), 32'd2);
        in_valid = 1'b1; #1;
        check(!in_ready, "R3 enabled and empty", 32'(in_ready), 32'd0);
        check(!req_valid, "R2 descriptors not reused", 32'(req_valid), 32'd0);
        in_valid = 1'b0;

        // R13: full flag and ignored overflow write
        do_reset();
        for (int i = 0; i < 4; i++) put_desc(32'h7000 + 32'(i) * 32'h100, 24'd4);
        @(negedge clk);
        check(desc_full && !desc_overflow, "R13 full after four", {30'd0, desc_full, desc_overflow}, 32'd2);
        put_desc(32'h9999_0000, 24'd4);
        @(negedge clk);
        check(desc_overflow, "R13 overflow set", 32'(desc_overflow), 32'd1);
        enable = 1'b1;
        for (int i = 0; i < 4; i++) send_beat(32'h7000 + 32'(i) * 32'h100, 1'b1, 1'b1, "R13 queued order");
        repeat (4) @(negedge clk);
        in_valid = 1'b1; #1;
        check(!in_ready, "R13 extra write was ignored", 32'(in_ready), 32'd0);
        in_valid = 1'b0;
        check(done_count == 4'd4, "R10 count four", 32'(done_count), 32'd4);
        check(desc_overflow, "R13 overflow sticky", 32'(desc_overflow), 32'd1);

        // R11 / R10: loop mode with counter wrap
        do_reset();
        put_desc(32'h5000, 24'd8);
        put_desc(32'h6000, 24'd6);
        @(negedge clk); loop_mode = 1'b1; enable = 1'b1;
        for (int r = 0; r < 9; r++) begin
            send_beat(32'h5000, 1'b0, 1'b1, "R11 loop D0 b0");
            send_beat(32'h5000, 1'b1, 1'b1, "R11 loop D0 b1");
            send_beat(32'h6000, 1'b0, 1'b1, "R7 loop D1 b0");
            send_beat(32'h6000, 1'b1, 1'b1, "R7 loop D1 b1");
        end
        repeat (4) @(negedge clk);
        check(done_count == 4'd2, "R10 wrap after 18", 32'(done_count), 32'd2);

        // R12: disable in the middle of a descriptor
        do_reset();
        put_desc(32'h3000, 24'd32);
        put_desc(32'h4000, 24'd4);
        @(negedge clk); enable = 1'b1;
        send_beat(32'h3000, 1'b0, 1'b1, "R12 pre b0");
        send_beat(32'h3000, 1'b0, 1'b1, "R12 pre b1");
        @(negedge clk); enable = 1'b0;
        send_beat(32'h3000, 1'b0, 1'b1, "R12 finish b2");
        send_beat(32'h3000, 1'b1, 1'b1, "R12 finish b3");
        send_beat(32'h0, 1'b0, 1'b0, "R12 discard after stop");
        repeat (3) @(negedge clk);
        check(done_count == 0, "R12 aborted not counted", 32'(done_count), 32'd0);
        enable = 1'b1;
        send_beat(32'h4000, 1'b1, 1'b1, "R12 next descriptor");
        repeat (4) @(negedge clk);
        check(done_count == 4'd1, "R12 next counted", 32'(done_count), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule